// File: doc/BRIEF.md
# Memory-Mapped Binary Calendar Clock

This peripheral keeps the calendar time (second, minute, hour, day of month, month, year within the century and century) as plain binary fields in two packed 32-bit words. A one-cycle pulse on `tick_i`, normally once per second, moves the time forward by one second. Months have their correct lengths, and the Gregorian leap-year rule applies. The block sits behind a small word-addressed register bus. Software reads the two time words and a control word. It loads a new time by setting an unlock flag and then writing the words.

Control holds two flags. A run flag lets ticks advance the time; while it is clear the time is frozen and reads return the frozen value. An unlock flag must be set before a counter word can be written. A counter write with the flag clear is dropped without any notice. The window also holds an alarm word and an alarm-status word. These are reserved: they read as zero and ignore writes.

Bus rules: `req_ready_o` is held high, so the block takes a request in every cycle where `req_valid_i` is high. A read returns its data one cycle after the request, with `rsp_valid_o` high for exactly that one cycle. The response path has no back-pressure, so the requester must be able to accept one response per read in every cycle. Writes produce no response.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset, the time word, the date word and the control word all read as zero, and `rsp_valid_o` is low.
- R2: The block decodes a 24-byte window using byte address bits [4:2] as the word index: 0x00 is the time word, 0x04 the date word, 0x10 control, 0x08 the alarm word and 0x14 the alarm status. Each accepted read returns data one cycle later with `rsp_valid_o` high for one cycle. Writes and idle cycles leave `rsp_valid_o` low. `req_ready_o` is always high.
- R3: Time word layout: day [28:24], hour [20:16], minute [13:8], second [5:0]. Date word layout: century [20:16], year [14:8], month [3:0]. Control layout: run [0], unlock [1]. All other bits read as zero.
- R4: A write to the time or date word while control bit 1 is clear changes nothing.
- R5: Control can be written at any time, and its bits 1:0 read back as written.
- R6: Time changes only on a tick while control bit 0 is set. While bit 0 is clear, ticks are ignored and reads return the stored time.
- R7: On a counted tick, a second at 59 or above wraps to 0 and carries into the minute. The minute and the hour wrap the same way, at 59 and at 23, into 0, and each carry moves to the next field up.
- R8: A day at or above the length of the current month wraps to 1 and carries into the month. February has 28 days, or 29 in a leap year. April, June, September and November have 30 days. Every other month value has 31.
- R9: For a year within the century of 0..99, the full year is century*100+year. It is a leap year when it divides by 4, except when it divides by 100 but not by 400.
- R10: A month at 12 or above wraps to 1 and carries into the year. A year at 99 or above wraps to 0 and carries into the century. The century wraps from 31 to 0.
- R11: A permitted counter write stores exactly its masked data, even if a tick arrives in the same cycle. That tick is dropped, and counting then continues from the loaded value.
- R12: The alarm word, the alarm status, offset 0x0C and every byte address at or above 0x18 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle seconds pulse |
| req_valid_i | input | 1 | Bus request present |
| req_ready_o | output | 1 | Request accepted (held high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The hardest states to reach are the deep carries. These are the century step at the end of year 99, the year-2100 and year-2000 leap-year cases, and February with 29 days. A plain run of ticks from reset would need years of simulated seconds to reach any of them. The stimulus therefore unlocks the counters, loads a date one second before each boundary and gives a single tick. It also puts a tick in the same cycle as a permitted write, and writes a day that is too large for the month loaded afterwards. A seeded random phase mixes control changes, loads of both legal and locked words, reads at any address and ticks, and checks every read against a bench calendar model.

// File: rtl/rtc_calendar_pkg.sv
package rtc_calendar_pkg;
  localparam int WORD_W       = 32;
  localparam int WINDOW_BYTES = 24;
  localparam int CTRL_RUN     = 0;
  localparam int CTRL_UNLOCK  = 1;

  localparam logic [WORD_W-1:0] TIME_MASK = 32'h1F1F_3F3F;
  localparam logic [WORD_W-1:0] DATE_MASK = 32'h001F_7F0F;

  typedef enum logic [1:0] {
    SEL_TIME,
    SEL_DATE,
    SEL_CTRL,
    SEL_NONE
  } rtc_sel_e;

  // Gregorian rule folded for year 0..99: divisibility by 4 follows the low
  // year bits; year 0 means the full year ends in 00, so the century decides.
  function automatic logic leap_year(input logic [4:0] cent, input logic [6:0] yr);
    if (yr != 7'd0) return (yr[1:0] == 2'b00);
    return (cent[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_field_step.sv
module rtc_field_step #(
  parameter int W = 6
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] last_i,
  input  logic [W-1:0] first_i,
  input  logic         inc_i,
  output logic [W-1:0] next_o,
  output logic         carry_o
);
  always_comb begin
    carry_o = inc_i && (val_i >= last_i);
    if (!inc_i)       next_o = val_i;
    else if (carry_o) next_o = first_i;
    else              next_o = val_i + W'(1);
  end
endmodule

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_calendar_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rtc_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(WINDOW_BYTES);

  logic in_window;
  assign in_window = (addr_i < WIN_END);

  always_comb begin
    sel_o = SEL_NONE;
    if (in_window) begin
      case (addr_i[4:2])
        3'd0:    sel_o = SEL_TIME;
        3'd1:    sel_o = SEL_DATE;
        3'd4:    sel_o = SEL_CTRL;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_calendar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              load_time_i,
  input  logic              load_date_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] time_o,
  output logic [WORD_W-1:0] date_o
);
  logic [WORD_W-1:0] time_q, date_q;

  logic [5:0] sec, min, sec_n, min_n;
  logic [4:0] hour, day, hour_n, day_n, cent, cent_n, dim;
  logic [6:0] year, year_n;
  logic [3:0] mon, mon_n;
  logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;

  assign sec  = time_q[5:0];
  assign min  = time_q[13:8];
  assign hour = time_q[20:16];
  assign day  = time_q[28:24];
  assign mon  = date_q[3:0];
  assign year = date_q[14:8];
  assign cent = date_q[20:16];

  assign dim = month_days(mon, leap_year(cent, year));

  rtc_field_step #(.W(6)) u_sec (
    .val_i(sec), .last_i(6'd59), .first_i(6'd0), .inc_i(step_i),
    .next_o(sec_n), .carry_o(c_sec));
  rtc_field_step #(.W(6)) u_min (
    .val_i(min), .last_i(6'd59), .first_i(6'd0), .inc_i(c_sec),
    .next_o(min_n), .carry_o(c_min));
  rtc_field_step #(.W(5)) u_hour (
    .val_i(hour), .last_i(5'd23), .first_i(5'd0), .inc_i(c_min),
    .next_o(hour_n), .carry_o(c_hour));
  rtc_field_step #(.W(5)) u_day (
    .val_i(day), .last_i(dim), .first_i(5'd1), .inc_i(c_hour),
    .next_o(day_n), .carry_o(c_day));
  rtc_field_step #(.W(4)) u_mon (
    .val_i(mon), .last_i(4'd12), .first_i(4'd1), .inc_i(c_day),
    .next_o(mon_n), .carry_o(c_mon));
  rtc_field_step #(.W(7)) u_year (
    .val_i(year), .last_i(7'd99), .first_i(7'd0), .inc_i(c_mon),
    .next_o(year_n), .carry_o(c_year));

  assign cent_n = cent + {4'd0, c_year};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
      date_q <= '0;
    end else begin
      if (load_time_i)  time_q <= wdata_i & TIME_MASK;
      else if (step_i)  time_q <= {3'd0, day_n, 3'd0, hour_n, 2'd0, min_n, 2'd0, sec_n};
      if (load_date_i)  date_q <= wdata_i & DATE_MASK;
      else if (step_i)  date_q <= {11'd0, cent_n, 1'b0, year_n, 4'd0, mon_n};
    end
  end

  assign time_o = time_q;
  assign date_o = date_q;
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
  import rtc_calendar_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_rdata_o
);
  rtc_sel_e          sel;
  logic [1:0]        ctrl_q;
  logic [WORD_W-1:0] time_word, date_word, rd_mux;
  logic              wr_fire, rd_fire, ld_time, ld_date, step;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_rdata_q;

  assign req_ready_o = 1'b1;
  assign wr_fire = req_valid_i &&  req_write_i;
  assign rd_fire = req_valid_i && !req_write_i;

  rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(req_addr_i),
    .sel_o (sel)
  );

  assign ld_time = wr_fire && (sel == SEL_TIME) && ctrl_q[CTRL_UNLOCK];
  assign ld_date = wr_fire && (sel == SEL_DATE) && ctrl_q[CTRL_UNLOCK];
  assign step    = tick_i && ctrl_q[CTRL_RUN] && !(ld_time || ld_date);

  rtc_calendar_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .load_time_i(ld_time),
    .load_date_i(ld_date),
    .wdata_i    (req_wdata_i),
    .time_o     (time_word),
    .date_o     (date_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (wr_fire && sel == SEL_CTRL) ctrl_q <= req_wdata_i[1:0];
  end

  always_comb begin
    case (sel)
      SEL_TIME: rd_mux = time_word;
      SEL_DATE: rd_mux = date_word;
      SEL_CTRL: rd_mux = {30'd0, ctrl_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_fire;
      if (rd_fire) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_calendar_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [WORD_W-1:0] req_wdata_i,
  input logic              rsp_valid_o,
  input logic [WORD_W-1:0] rsp_rdata_o,
  input logic [1:0]        ctrl_q,
  input logic [WORD_W-1:0] time_word,
  input logic [WORD_W-1:0] date_word
);
  logic [ADDR_W-1:0] widx;
  logic in_win, wr, rd, perm_time, perm_any;

  assign widx      = req_addr_i >> 2;
  assign in_win    = req_addr_i < ADDR_W'(WINDOW_BYTES);
  assign wr        = req_valid_i && req_write_i;
  assign rd        = req_valid_i && !req_write_i;
  assign perm_time = wr && in_win && (widx == ADDR_W'(0)) && ctrl_q[1];
  assign perm_any  = wr && in_win && (widx <= ADDR_W'(1)) && ctrl_q[1];

  // R4: locked, stopped clock keeps both words across any write
  p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ctrl_q == 2'b00) |=> ($stable(time_word) && $stable(date_word)));

  // R6: stopped clock does not move without a permitted load
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !perm_any) |=> ($stable(time_word) && $stable(date_word)));

  // R6: no tick, no load, no change
  p_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !perm_any) |=> ($stable(time_word) && $stable(date_word)));

  // R11: permitted time load is exact, tick or not
  p_exact_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    perm_time |=> (time_word == ($past(req_wdata_i) & TIME_MASK)));

  // R7: second wrap
  p_sec_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && tick_i && !perm_any && time_word[5:0] == 6'd59) |=> (time_word[5:0] == 6'd0));

  // R2: one response per read, none otherwise
  p_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid_o);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid_o);

  // R12: alarm word reads zero
  p_alarm_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && widx == ADDR_W'(2)) |=> (rsp_rdata_o == '0));

  // R5: control always writable
  p_ctrl_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == ADDR_W'(4)) |=> (ctrl_q == $past(req_wdata_i[1:0])));
endmodule

bind rtc_calendar_top rtc_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .ctrl_q     (ctrl_q),
  .time_word  (time_word),
  .date_word  (date_word)
);

// File: tb/rtc_calendar_top_tb_top.sv
module rtc_calendar_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_cent, m_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pk_time(int d, int h, int mi, int s);
    return {3'd0, 5'(d), 3'd0, 5'(h), 2'd0, 6'(mi), 2'd0, 6'(s)};
  endfunction

  function automatic logic [31:0] pk_date(int c, int y, int mo);
    return {11'd0, 5'(c), 1'b0, 7'(y), 4'd0, 4'(mo)};
  endfunction

  function automatic bit m_leap(int c, int y);
    int fy;
    fy = c * 100 + y;
    return (fy % 4 == 0) && ((fy % 100 != 0) || (fy % 400 == 0));
  endfunction

  function automatic int m_dim(int mo, bit lp);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a >= 8'd24) return 32'd0;
    case (a[4:2])
      3'd0:    return pk_time(m_day, m_hour, m_min, m_sec);
      3'd1:    return pk_date(m_cent, m_year, m_mon);
      3'd4:    return {30'd0, 2'(m_ctl)};
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_tick();
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (m_hour < 23) begin m_hour++; return; end
    m_hour = 0;
    if (m_day < m_dim(m_mon, m_leap(m_cent, m_year))) begin m_day++; return; end
    m_day = 1;
    if (m_mon < 12) begin m_mon++; return; end
    m_mon = 1;
    if (m_year < 99) begin m_year++; return; end
    m_year = 0;
    m_cent = (m_cent + 1) % 32;
  endtask

  task automatic step(input bit tk, input bit v, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] exp;
    bit permit;
    tick_i = tk; req_valid_i = v; req_write_i = w; req_addr_i = a; req_wdata_i = d;
    exp = m_read(a);
    @(posedge clk); #1;
    if (v && !w) begin
      chk({tag, " rsp_valid (R2)"}, {31'd0, rsp_valid_o}, 32'd1);
      chk(tag, rsp_rdata_o, exp);
    end else begin
      chk("R2 no response without read", {31'd0, rsp_valid_o}, 32'd0);
    end
    permit = 0;
    if (v && w && a < 8'd24) begin
      if (a[4:2] == 3'd0 && m_ctl[1]) begin
        m_day = d[28:24]; m_hour = d[20:16]; m_min = d[13:8]; m_sec = d[5:0]; permit = 1;
      end else if (a[4:2] == 3'd1 && m_ctl[1]) begin
        m_cent = d[20:16]; m_year = d[14:8]; m_mon = d[3:0]; permit = 1;
      end
    end
    if (tk && m_ctl[0] && !permit) m_tick();
    if (v && w && a < 8'd24 && a[4:2] == 3'd4) m_ctl = d[1:0];
    @(negedge clk);
    tick_i = 0; req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(0, 1, 1, a, d, "write");
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(0, 0 == 1 ? 0 : 1, 0, a, 32'd0, tag);
  endtask
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 8'd0, 32'd0, "tick");
  endtask

  task automatic load(int c, int y, int mo, int d, int h, int mi, int s);
    wr(8'h10, 32'd2);
    wr(8'h04, pk_date(c, y, mo));
    wr(8'h00, pk_time(d, h, mi, s));
    wr(8'h10, 32'd3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd51723));
    m_sec = 0; m_min = 0; m_hour = 0; m_day = 0; m_mon = 0; m_year = 0; m_cent = 0; m_ctl = 0;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", {31'd0, rsp_valid_o}, 32'd0);
    chk("R2 ready high", {31'd0, req_ready_o}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, "R1 time zero");
    rd(8'h04, "R1 date zero");
    rd(8'h10, "R1 ctrl zero");

    // R4 locked writes dropped
    wr(8'h00, pk_time(5, 6, 7, 8));
    wr(8'h04, pk_date(20, 24, 3));
    rd(8'h00, "R4 locked time");
    rd(8'h04, "R4 locked date");

    // R5 control writable, R3 unused bits zero
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, "R5 R3 ctrl readback");
    wr(8'h10, 32'd2);
    rd(8'h10, "R5 ctrl readback 2");
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, "R3 time mask");
    rd(8'h04, "R3 date mask");

    // R7 hour/day chain
    load(20, 24, 5, 10, 23, 59, 59); tk(1);
    rd(8'h00, "R7 midnight time"); rd(8'h04, "R7 midnight date");
    load(20, 24, 5, 10, 12, 30, 58); tk(3);
    rd(8'h00, "R7 plain seconds");
    // R8 R9 leap cases
    load(20, 24, 2, 28, 23, 59, 59); tk(1); rd(8'h00, "R9 2024 feb 29"); rd(8'h04, "R9 2024 date");
    tk(86400 / 86400); rd(8'h00, "R7 after one more second");
    load(20, 24, 2, 29, 23, 59, 59); tk(1); rd(8'h00, "R8 feb 29 wrap"); rd(8'h04, "R8 to march");
    load(20, 23, 2, 28, 23, 59, 59); tk(1); rd(8'h04, "R9 2023 no leap");
    load(21, 0, 2, 28, 23, 59, 59); tk(1); rd(8'h04, "R9 2100 no leap");
    load(20, 0, 2, 28, 23, 59, 59); tk(1); rd(8'h04, "R9 2000 leap"); rd(8'h00, "R9 2000 day");
    load(20, 24, 4, 30, 23, 59, 59); tk(1); rd(8'h04, "R8 april 30"); rd(8'h00, "R8 april day");
    load(20, 24, 1, 31, 23, 59, 59); tk(1); rd(8'h04, "R8 january 31");
    load(20, 24, 2, 31, 23, 59, 59); tk(1); rd(8'h04, "R8 oversize day"); rd(8'h00, "R8 oversize day time");
    // R10 year and century carries
    load(20, 99, 12, 31, 23, 59, 59); tk(1); rd(8'h04, "R10 century carry"); rd(8'h00, "R10 new year time");
    load(31, 99, 12, 31, 23, 59, 59); tk(1); rd(8'h04, "R10 century wrap");
    load(20, 24, 12, 31, 23, 59, 59); tk(1); rd(8'h04, "R10 year carry");

    // R6 stopped clock
    wr(8'h10, 32'd2); tk(5);
    rd(8'h00, "R6 frozen time"); rd(8'h04, "R6 frozen date");
    wr(8'h10, 32'd3); tk(4); rd(8'h00, "R6 running again");

    // R11 tick collides with load
    step(1, 1, 1, 8'h00, pk_time(3, 4, 5, 59), "R11 collide");
    rd(8'h00, "R11 exact value");
    step(1, 1, 1, 8'h04, pk_date(19, 99, 12), "R11 collide date");
    rd(8'h00, "R11 time untouched"); rd(8'h04, "R11 exact date");
    tk(1); rd(8'h00, "R11 continues");

    // R12 reserved and unmapped
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_0000); wr(8'hF0, 32'h0000_0000); wr(8'h1C, 32'h0);
    rd(8'h08, "R12 alarm zero"); rd(8'h14, "R12 status zero");
    rd(8'h0C, "R12 gap zero"); rd(8'h18, "R12 beyond window"); rd(8'h90, "R12 far");
    rd(8'h10, "R12 ctrl untouched"); rd(8'h00, "R12 time untouched"); rd(8'h04, "R12 date untouched");
    rd(8'h13, "R2 low address bits ignored");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 10;
      case (r)
        0, 1, 2, 3, 4: begin
          logic [7:0] a;
          case ($urandom % 3) 0: a = 8'h00; 1: a = 8'h04; default: a = 8'h10; endcase
          step(1, 1'($urandom % 2), 0, a, 32'd0, "R6 R7 random tick read");
        end
        5: step(0, 1, 1, 8'h10, ($urandom % 4 == 0) ? $urandom : 32'd3, "R5 random ctrl");
        6: step(1'($urandom % 2), 1, 1, 8'h00,
                pk_time(1 + $urandom % 31, $urandom % 24, $urandom % 60, $urandom % 60)
                | ($urandom & ~32'h1F1F_3F3F), "R11 random time load");
        7: step(1'($urandom % 2), 1, 1, 8'h04,
                pk_date($urandom % 32, $urandom % 100, 1 + $urandom % 12)
                | ($urandom & ~32'h001F_7F0F), "R11 random date load");
        8: step(1'($urandom % 2), 1, 0, 8'($urandom), 32'd0, "R2 random read");
        default: begin
          logic [7:0] a;
          case ($urandom % 4) 0: a = 8'h08; 1: a = 8'h0C; 2: a = 8'h14;
            default: a = 8'd24 + 8'($urandom % 232); endcase
          step(1'($urandom % 2), 1, 1, a, $urandom, "R12 random reserved write");
        end
      endcase
    end
    rd(8'h00, "R7 final time"); rd(8'h04, "R10 final date");
    finish_run();
  end
endmodule